// File: doc/BRIEF.md
# CCD readout clock sequencer

This block produces the digital phase pattern for a four-quadrant full-frame CCD over one complete exposure. Each frame starts with a flush pass that sweeps charge out of the array, then holds the vertical clocks still for a programmed integration time. It then reads the array out line by line, either at full resolution or with 3x3 charge binning. The outputs are the two vertical phases, the two horizontal phases, the last horizontal phase and the reset gate. A clamp strobe and a sample strobe go to the downstream converter, with pulses marking line and frame boundaries.

All durations are counts of system-clock cycles, and the block captures them when a start command is accepted. The line geometry is fixed by parameters: lines per quadrant, and dummy, dark, buffer and image cells per line. A line is the sum of those four cell counts. Overclock counts add extra pixels to each readout line and extra lines to each frame. Level shifting and the analog drivers sit outside this block.

Top module: `ccd_clock_sequencer`

## Requirements
- R1: Out of reset and while idle: v1, v2, h2, rg, clamp and sample are low; h1 and hl are high; busy is low.
- R2: A start pulse while idle begins a frame. frame_start pulses for one cycle in the next cycle, and busy stays high until frame_done pulses for one cycle, in the first cycle after busy falls. A start while busy is ignored.
- R3: The flush pass makes max(programmed flush lines, LINES) vertical transfers, then max(programmed flush pixels, line length) horizontal pixel periods. It issues no clamp or sample strobes.
- R4: During integration v1, v2, h2 and rg stay low for exactly the programmed integration count. That window directly precedes the first line_start.
- R5: Each vertical transfer drives v1 high for tv cycles and then v2 high for tv cycles, never both at once. A line enters the horizontal register on the falling edge of v2. h1 is high and h2 is low for the whole transfer.
- R6: After the last vertical transfer of a line, the block waits the programmed setup count before the first horizontal pixel period. v2 falling to the first h2 rise is therefore setup plus half a pixel period.
- R7: A pixel period of P cycles holds h1 and hl high for the first floor(P/2) cycles and h2 high for the rest. That gives one falling edge of hl per pixel. A readout line has line length plus the pixel overclock count.
- R8: In full-resolution readout, rg is high for the first rg-width cycles of every pixel. Clamp pulses once at the clamp offset and sample pulses once at the sample offset. rg also pulses every pixel during flush.
- R9: Full-resolution readout has LINES plus the line overclock count. Each line begins with one line_start pulse in the first v1 cycle of its transfer.
- R10: Binned readout makes three vertical transfers per output line and has ceil(LINES/3) plus the line overclock count. rg and clamp occur only in the first pixel of each group of three, and sample only in the third.
- R11: The frame lasts 1 + F*2tv + Fp*P + I + N*(k*2tv + S + Np*P) cycles from frame_start to frame_done. Here F and Fp are the effective flush counts, I is the integration count, N is the line count, k is 1 or 3, S is the setup count and Np is pixels per line.
- R12: Timing inputs changed after a start is accepted have no effect on the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start command |
| binned_i | input | 1 | 1 selects 3x3 binned readout |
| integ_cycles_i | input | INT_W | Integration length in cycles |
| tv_cycles_i | input | CNT_W | High time of each vertical phase |
| setup_cycles_i | input | CNT_W | Horizontal setup after vertical transfer |
| pix_cycles_i | input | PIX_W | Pixel period in cycles |
| rg_width_i | input | PIX_W | Reset gate high cycles per pixel |
| clamp_off_i | input | PIX_W | Clamp strobe offset within pixel |
| sample_off_i | input | PIX_W | Sample strobe offset within pixel |
| flush_lines_i | input | CNT_W | Requested flush vertical transfers |
| flush_pix_i | input | CNT_W | Requested flush pixel periods |
| ovc_pix_i | input | CNT_W | Extra pixels per readout line |
| ovc_lines_i | input | CNT_W | Extra lines per frame |
| v1_o | output | 1 | Vertical phase 1 |
| v2_o | output | 1 | Vertical phase 2 |
| h1_o | output | 1 | Horizontal phase 1 |
| h2_o | output | 1 | Horizontal phase 2 |
| hl_o | output | 1 | Last horizontal phase |
| rg_o | output | 1 | Reset gate |
| clamp_o | output | 1 | Converter clamp strobe |
| sample_o | output | 1 | Converter sample strobe |
| line_start_o | output | 1 | Readout line start pulse |
| frame_start_o | output | 1 | Frame start pulse |
| frame_done_o | output | 1 | Frame complete pulse |
| busy_o | output | 1 | Frame in progress |

## Verification
The strobe checks assume that the clamp and sample offsets are at or beyond the reset-gate width and inside the pixel period, so no strobe overlaps rg. Every configuration the bench drives keeps to that, with a pixel period of at least four cycles. The start checks assume a start pulse lasts one cycle. The bench drives it for a single clock and raises it again only on purpose in mid-frame, which exercises the rejection path.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH_V,
    ST_FLUSH_H,
    ST_INTEG,
    ST_RD_V,
    ST_RD_SETUP,
    ST_RD_H
  } seq_state_e;
endpackage

// File: rtl/ccd_seq_cfg.sv
module ccd_seq_cfg #(
  parameter int CNT_W = 16,
  parameter int INT_W = 32,
  parameter int PIX_W = 8,
  parameter int LINES = 1536,
  parameter int NPIX  = 1546
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             binned_i,
  input  logic [INT_W-1:0] integ_i,
  input  logic [CNT_W-1:0] tv_i,
  input  logic [CNT_W-1:0] ths_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] rg_w_i,
  input  logic [PIX_W-1:0] clamp_i,
  input  logic [PIX_W-1:0] sample_i,
  input  logic [CNT_W-1:0] flush_lines_i,
  input  logic [CNT_W-1:0] flush_pix_i,
  input  logic [CNT_W-1:0] ovc_pix_i,
  input  logic [CNT_W-1:0] ovc_lines_i,
  output logic             binned_o,
  output logic [INT_W-1:0] integ_o,
  output logic [CNT_W-1:0] tv_o,
  output logic [CNT_W-1:0] ths_o,
  output logic [PIX_W-1:0] pix_o,
  output logic [PIX_W-1:0] rg_w_o,
  output logic [PIX_W-1:0] clamp_o,
  output logic [PIX_W-1:0] sample_o,
  output logic [CNT_W-1:0] flush_lines_o,
  output logic [CNT_W-1:0] flush_pix_o,
  output logic [CNT_W-1:0] npix_rd_o,
  output logic [CNT_W-1:0] nlines_o
);
  localparam int BIN_LINES = (LINES + 2) / 3;
  localparam logic [CNT_W-1:0] LINES_C = CNT_W'(LINES);
  localparam logic [CNT_W-1:0] BIN_C   = CNT_W'(BIN_LINES);
  localparam logic [CNT_W-1:0] NPIX_C  = CNT_W'(NPIX);

  // Frame parameters are frozen here at start; minimums are enforced once.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      binned_o      <= 1'b0;
      integ_o       <= INT_W'(1);
      tv_o          <= CNT_W'(1);
      ths_o         <= CNT_W'(1);
      pix_o         <= PIX_W'(2);
      rg_w_o        <= PIX_W'(1);
      clamp_o       <= PIX_W'(1);
      sample_o      <= PIX_W'(1);
      flush_lines_o <= LINES_C;
      flush_pix_o   <= NPIX_C;
      npix_rd_o     <= NPIX_C;
      nlines_o      <= LINES_C;
    end else if (load_i) begin
      binned_o      <= binned_i;
      integ_o       <= (integ_i == '0) ? INT_W'(1) : integ_i;
      tv_o          <= (tv_i == '0) ? CNT_W'(1) : tv_i;
      ths_o         <= (ths_i == '0) ? CNT_W'(1) : ths_i;
      pix_o         <= (pix_i < PIX_W'(2)) ? PIX_W'(2) : pix_i;
      rg_w_o        <= rg_w_i;
      clamp_o       <= clamp_i;
      sample_o      <= sample_i;
      flush_lines_o <= (flush_lines_i < LINES_C) ? LINES_C : flush_lines_i;
      flush_pix_o   <= (flush_pix_i < NPIX_C) ? NPIX_C : flush_pix_i;
      npix_rd_o     <= NPIX_C + ovc_pix_i;
      nlines_o      <= (binned_i ? BIN_C : LINES_C) + ovc_lines_i;
    end
  end
endmodule

// File: rtl/ccd_seq_vert.sv
module ccd_seq_vert #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] tv_i,
  output logic             v1_o,
  output logic             v2_o,
  output logic             done_o
);
  logic             act_q;
  logic             ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             seg_end;

  assign seg_end = (cnt_q == tv_i - CNT_W'(1));
  assign done_o  = act_q & ph_q & seg_end;
  assign v1_o    = act_q & ~ph_q;
  assign v2_o    = act_q & ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      ph_q  <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      ph_q  <= 1'b0;
      cnt_q <= '0;
    end else if (act_q) begin
      if (seg_end) begin
        cnt_q <= '0;
        if (ph_q) act_q <= 1'b0;
        else      ph_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ccd_seq_hpix.sv
module ccd_seq_hpix #(
  parameter int CNT_W = 16,
  parameter int PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] npix_i,
  input  logic             rd_i,
  input  logic             binned_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] rg_w_i,
  input  logic [PIX_W-1:0] clamp_off_i,
  input  logic [PIX_W-1:0] sample_off_i,
  output logic             h1_o,
  output logic             h2_o,
  output logic             hl_o,
  output logic             rg_o,
  output logic             clamp_o,
  output logic             sample_o,
  output logic             done_o
);
  logic             act_q, rd_q, bin_q;
  logic [PIX_W-1:0] pc_q;
  logic [CNT_W-1:0] idx_q, npix_q;
  logic [1:0]       grp_q;
  logic             pix_end, line_end, first_half, rg_slot, smp_slot;

  assign pix_end    = (pc_q == pix_i - PIX_W'(1));
  assign line_end   = (idx_q == npix_q - CNT_W'(1));
  assign done_o     = act_q & pix_end & line_end;
  assign first_half = (pc_q < (pix_i >> 1));

  // Binned: one reset per three-pixel group, sample after the third charge.
  assign rg_slot  = ~bin_q | (grp_q == 2'd0);
  assign smp_slot = ~bin_q | (grp_q == 2'd2);

  assign h1_o     = ~act_q | first_half;
  assign hl_o     = ~act_q | first_half;
  assign h2_o     = act_q & ~first_half;
  assign rg_o     = act_q & (pc_q < rg_w_i) & rg_slot;
  assign clamp_o  = act_q & rd_q & (pc_q == clamp_off_i) & rg_slot;
  assign sample_o = act_q & rd_q & (pc_q == sample_off_i) & smp_slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
      bin_q  <= 1'b0;
      pc_q   <= '0;
      idx_q  <= '0;
      npix_q <= '0;
      grp_q  <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      rd_q   <= rd_i;
      bin_q  <= rd_i & binned_i;
      pc_q   <= '0;
      idx_q  <= '0;
      npix_q <= npix_i;
      grp_q  <= '0;
    end else if (act_q) begin
      if (pix_end) begin
        pc_q <= '0;
        if (line_end) begin
          act_q <= 1'b0;
        end else begin
          idx_q <= idx_q + CNT_W'(1);
          grp_q <= (grp_q == 2'd2) ? 2'd0 : grp_q + 2'd1;
        end
      end else begin
        pc_q <= pc_q + PIX_W'(1);
      end
    end
  end
endmodule

// File: rtl/ccd_clock_sequencer.sv
module ccd_clock_sequencer
  import ccd_seq_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int INT_W     = 32,
  parameter int PIX_W     = 8,
  parameter int LINES     = 1536,
  parameter int DUMMY_PIX = 10,
  parameter int DARK_PIX  = 20,
  parameter int BUF_PIX   = 4,
  parameter int IMG_PIX   = 1512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             binned_i,
  input  logic [INT_W-1:0] integ_cycles_i,
  input  logic [CNT_W-1:0] tv_cycles_i,
  input  logic [CNT_W-1:0] setup_cycles_i,
  input  logic [PIX_W-1:0] pix_cycles_i,
  input  logic [PIX_W-1:0] rg_width_i,
  input  logic [PIX_W-1:0] clamp_off_i,
  input  logic [PIX_W-1:0] sample_off_i,
  input  logic [CNT_W-1:0] flush_lines_i,
  input  logic [CNT_W-1:0] flush_pix_i,
  input  logic [CNT_W-1:0] ovc_pix_i,
  input  logic [CNT_W-1:0] ovc_lines_i,
  output logic             v1_o,
  output logic             v2_o,
  output logic             h1_o,
  output logic             h2_o,
  output logic             hl_o,
  output logic             rg_o,
  output logic             clamp_o,
  output logic             sample_o,
  output logic             line_start_o,
  output logic             frame_start_o,
  output logic             frame_done_o,
  output logic             busy_o
);
  localparam int NPIX = DUMMY_PIX + DARK_PIX + BUF_PIX + IMG_PIX;

  logic             c_binned;
  logic [INT_W-1:0] c_integ;
  logic [CNT_W-1:0] c_tv, c_ths, c_flush_lines, c_flush_pix, c_npix_rd, c_nlines;
  logic [PIX_W-1:0] c_pix, c_rg_w, c_clamp, c_sample;

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] line_q, line_d;
  logic [1:0]       vsub_q, vsub_d;
  logic [INT_W-1:0] wait_q, wait_d;
  logic             kick_q, fs_q, fd_q, ls_q;
  logic             fd_d, ls_d, accept;
  logic             v_start, v_done, h_start, h_done, h_rd;
  logic [CNT_W-1:0] h_npix;

  assign accept = (st_q == ST_IDLE) & start_i;

  ccd_seq_cfg #(
    .CNT_W(CNT_W), .INT_W(INT_W), .PIX_W(PIX_W), .LINES(LINES), .NPIX(NPIX)
  ) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (accept),
    .binned_i     (binned_i),
    .integ_i      (integ_cycles_i),
    .tv_i         (tv_cycles_i),
    .ths_i        (setup_cycles_i),
    .pix_i        (pix_cycles_i),
    .rg_w_i       (rg_width_i),
    .clamp_i      (clamp_off_i),
    .sample_i     (sample_off_i),
    .flush_lines_i(flush_lines_i),
    .flush_pix_i  (flush_pix_i),
    .ovc_pix_i    (ovc_pix_i),
    .ovc_lines_i  (ovc_lines_i),
    .binned_o     (c_binned),
    .integ_o      (c_integ),
    .tv_o         (c_tv),
    .ths_o        (c_ths),
    .pix_o        (c_pix),
    .rg_w_o       (c_rg_w),
    .clamp_o      (c_clamp),
    .sample_o     (c_sample),
    .flush_lines_o(c_flush_lines),
    .flush_pix_o  (c_flush_pix),
    .npix_rd_o    (c_npix_rd),
    .nlines_o     (c_nlines)
  );

  ccd_seq_vert #(.CNT_W(CNT_W)) u_vert (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(v_start),
    .tv_i   (c_tv),
    .v1_o   (v1_o),
    .v2_o   (v2_o),
    .done_o (v_done)
  );

  ccd_seq_hpix #(.CNT_W(CNT_W), .PIX_W(PIX_W)) u_hpix (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (h_start),
    .npix_i      (h_npix),
    .rd_i        (h_rd),
    .binned_i    (c_binned),
    .pix_i       (c_pix),
    .rg_w_i      (c_rg_w),
    .clamp_off_i (c_clamp),
    .sample_off_i(c_sample),
    .h1_o        (h1_o),
    .h2_o        (h2_o),
    .hl_o        (hl_o),
    .rg_o        (rg_o),
    .clamp_o     (clamp_o),
    .sample_o    (sample_o),
    .done_o      (h_done)
  );

  always_comb begin
    st_d    = st_q;
    line_d  = line_q;
    vsub_d  = vsub_q;
    wait_d  = wait_q;
    v_start = 1'b0;
    h_start = 1'b0;
    h_rd    = 1'b0;
    h_npix  = c_flush_pix;
    fd_d    = 1'b0;
    ls_d    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_FLUSH_V;
          line_d = '0;
        end
      end
      ST_FLUSH_V: begin
        // Config is live one cycle after accept, so the first transfer is kicked here.
        if (kick_q) begin
          v_start = 1'b1;
        end else if (v_done) begin
          if (line_q == c_flush_lines - CNT_W'(1)) begin
            st_d    = ST_FLUSH_H;
            h_start = 1'b1;
            line_d  = '0;
          end else begin
            line_d  = line_q + CNT_W'(1);
            v_start = 1'b1;
          end
        end
      end
      ST_FLUSH_H: begin
        if (h_done) begin
          st_d   = ST_INTEG;
          wait_d = '0;
        end
      end
      ST_INTEG: begin
        if (wait_q == c_integ - INT_W'(1)) begin
          st_d    = ST_RD_V;
          v_start = 1'b1;
          ls_d    = 1'b1;
          line_d  = '0;
          vsub_d  = '0;
        end else begin
          wait_d = wait_q + INT_W'(1);
        end
      end
      ST_RD_V: begin
        if (v_done) begin
          if (c_binned && (vsub_q != 2'd2)) begin
            vsub_d  = vsub_q + 2'd1;
            v_start = 1'b1;
          end else begin
            st_d   = ST_RD_SETUP;
            wait_d = '0;
          end
        end
      end
      ST_RD_SETUP: begin
        h_rd   = 1'b1;
        h_npix = c_npix_rd;
        if (wait_q == INT_W'(c_ths) - INT_W'(1)) begin
          st_d    = ST_RD_H;
          h_start = 1'b1;
        end else begin
          wait_d = wait_q + INT_W'(1);
        end
      end
      ST_RD_H: begin
        if (h_done) begin
          if (line_q == c_nlines - CNT_W'(1)) begin
            st_d = ST_IDLE;
            fd_d = 1'b1;
          end else begin
            st_d    = ST_RD_V;
            line_d  = line_q + CNT_W'(1);
            vsub_d  = '0;
            v_start = 1'b1;
            ls_d    = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      line_q <= '0;
      vsub_q <= '0;
      wait_q <= '0;
      kick_q <= 1'b0;
      fs_q   <= 1'b0;
      fd_q   <= 1'b0;
      ls_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      line_q <= line_d;
      vsub_q <= vsub_d;
      wait_q <= wait_d;
      kick_q <= accept;
      fs_q   <= accept;
      fd_q   <= fd_d;
      ls_q   <= ls_d;
    end
  end

  assign busy_o        = (st_q != ST_IDLE);
  assign frame_start_o = fs_q;
  assign frame_done_o  = fd_q;
  assign line_start_o  = ls_q;
endmodule

// File: rtl/ccd_seq_chk.sv
module ccd_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic integ_i,
  input logic v1_i,
  input logic v2_i,
  input logic h1_i,
  input logic h2_i,
  input logic rg_i,
  input logic clamp_i,
  input logic sample_i,
  input logic line_start_i,
  input logic frame_start_i,
  input logic frame_done_i,
  input logic busy_i
);
  p_quiet_integ_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    integ_i |-> (!v1_i && !v2_i && !h2_i && !rg_i));

  p_no_v_overlap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(v1_i && v2_i));

  p_h1_hold_at_v2_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(v2_i) |-> (h1_i && !h2_i));

  p_h_still_in_vxfer_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v1_i || v2_i) |-> (h1_i && !h2_i));

  p_start_ignored_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i) |=> !frame_start_i);

  p_start_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |-> (busy_i && $past(start_i)));

  p_done_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i |-> !busy_i);

  p_done_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i |=> !frame_done_i);

  p_strobe_clear_of_rg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clamp_i || sample_i) |-> !rg_i);

  p_line_start_v1_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |-> v1_i);
endmodule

bind ccd_clock_sequencer ccd_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .integ_i      (st_q == ccd_seq_pkg::ST_INTEG),
  .v1_i         (v1_o),
  .v2_i         (v2_o),
  .h1_i         (h1_o),
  .h2_i         (h2_o),
  .rg_i         (rg_o),
  .clamp_i      (clamp_o),
  .sample_i     (sample_o),
  .line_start_i (line_start_o),
  .frame_start_i(frame_start_o),
  .frame_done_i (frame_done_o),
  .busy_i       (busy_o)
);

// File: tb/ccd_clock_sequencer_bench.sv
module ccd_clock_sequencer_bench;
  localparam int CNT_W = 16, INT_W = 32, PIX_W = 8;

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0, binned = 1'b0;
  logic [INT_W-1:0] integ;
  logic [CNT_W-1:0] tv, ths, fl_lines, fl_pix, ovc_pix, ovc_lines;
  logic [PIX_W-1:0] pix, rg_w, clamp_off, sample_off;
  logic v1, v2, h1, h2, hl, rg, clamp, sample, ls, fs, fd, busy;

  always #10 clk = ~clk;

  ccd_clock_sequencer #(
    .CNT_W(CNT_W), .INT_W(INT_W), .PIX_W(PIX_W), .LINES(6),
    .DUMMY_PIX(1), .DARK_PIX(2), .BUF_PIX(1), .IMG_PIX(2)
  ) u_ccd_clock_sequencer (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .binned_i(binned),
    .integ_cycles_i(integ), .tv_cycles_i(tv), .setup_cycles_i(ths),
    .pix_cycles_i(pix), .rg_width_i(rg_w), .clamp_off_i(clamp_off),
    .sample_off_i(sample_off), .flush_lines_i(fl_lines), .flush_pix_i(fl_pix),
    .ovc_pix_i(ovc_pix), .ovc_lines_i(ovc_lines),
    .v1_o(v1), .v2_o(v2), .h1_o(h1), .h2_o(h2), .hl_o(hl), .rg_o(rg),
    .clamp_o(clamp), .sample_o(sample), .line_start_o(ls),
    .frame_start_o(fs), .frame_done_o(fd), .busy_o(busy)
  );

  int n_tests = 0, n_fail = 0;
  int cyc, fs_cyc, frame_len, v2_falls, hl_falls, rg_rises, rg_cyc, h2_cyc;
  int clamps, samples, lstarts, fstarts, fdones, fl_v2, fl_hl, fl_smp;
  int quiet_run, quiet_before, bad_v2h1, order_bad, last_v2f, setup_dist;
  bit seen_ls, seen_clamp, p_v2, p_hl, p_h2, p_rg;

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic mon_clear();
    cyc = 0; fs_cyc = 0; frame_len = -1; v2_falls = 0; hl_falls = 0; rg_rises = 0;
    rg_cyc = 0; h2_cyc = 0; clamps = 0; samples = 0; lstarts = 0; fstarts = 0;
    fdones = 0; fl_v2 = 0; fl_hl = 0; fl_smp = 0; quiet_run = 0; quiet_before = -1;
    bad_v2h1 = 0; order_bad = 0; last_v2f = 0; setup_dist = -1; seen_ls = 0;
    seen_clamp = 0; p_v2 = 0; p_hl = 1; p_h2 = 0; p_rg = 0;
  endtask

  always @(negedge clk) if (rst_ni) begin
    cyc++;
    if (ls) begin
      lstarts++;
      if (!seen_ls) quiet_before = quiet_run;
      seen_ls = 1;
    end
    if (!v1 && !v2 && !h2 && !rg) quiet_run++; else quiet_run = 0;
    if (p_v2 && !v2) begin
      v2_falls++;
      if (!seen_ls) fl_v2++;
      if (!h1 || h2) bad_v2h1++;
      last_v2f = cyc;
    end
    if (p_hl && !hl) begin hl_falls++; if (!seen_ls) fl_hl++; end
    if (!p_h2 && h2 && seen_ls && setup_dist < 0) setup_dist = cyc - last_v2f;
    if (!p_rg && rg) begin rg_rises++; seen_clamp = 0; end
    if (rg) rg_cyc++;
    if (h2) h2_cyc++;
    if (clamp) begin clamps++; seen_clamp = 1; end
    if (sample) begin
      samples++;
      if (!seen_ls) fl_smp++;
      if (!seen_clamp) order_bad++;
    end
    if (fs) begin fstarts++; fs_cyc = cyc; end
    if (fd) begin fdones++; frame_len = cyc - fs_cyc; end
    p_v2 = v2; p_hl = hl; p_h2 = h2; p_rg = rg;
  end

  task automatic set_default();
    binned = 0; integ = 20; tv = 2; ths = 3; pix = 4; rg_w = 1; clamp_off = 1;
    sample_off = 3; fl_lines = 0; fl_pix = 0; ovc_pix = 0; ovc_lines = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_done(string req);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (fdones > 0) return;
    end
    check({req, " watchdog"}, 0, 1);
  endtask

  task automatic t_reset();
    check("R1 v1", int'(v1), 0);   check("R1 v2", int'(v2), 0);
    check("R1 h1", int'(h1), 1);   check("R1 hl", int'(hl), 1);
    check("R1 h2", int'(h2), 0);   check("R1 rg", int'(rg), 0);
    check("R1 sample", int'(sample), 0); check("R1 clamp", int'(clamp), 0);
    check("R1 busy", int'(busy), 0);
  endtask

  task automatic t_full();
    set_default(); mon_clear(); pulse_start(); wait_done("R11 full");
    check("R11 full frame length", frame_len, 255);
    check("R2 one frame_start", fstarts, 1);
    check("R2 busy low at done", int'(busy), 0);
    check("R3 flush lines at minimum", fl_v2, 6);
    check("R3 flush pixels at minimum", fl_hl, 6);
    check("R3 no sample in flush", fl_smp, 0);
    check("R4 integration quiet length", quiet_before, 20);
    check("R5 v2 falls", v2_falls, 12);
    check("R5 h1 high at v2 fall", bad_v2h1, 0);
    check("R6 setup to h2 rise", setup_dist, 5);
    check("R7 hl falls", hl_falls, 42);
    check("R7 h2 high cycles", h2_cyc, 84);
    check("R8 rg pulses", rg_rises, 42);
    check("R8 clamps", clamps, 36);
    check("R8 samples", samples, 36);
    check("R8 rg clamp sample order", order_bad, 0);
    check("R9 line starts", lstarts, 6);
    @(negedge clk);
    check("R1 idle after frame h1", int'(h1), 1);
    check("R1 idle after frame v1", int'(v1), 0);
  endtask

  task automatic t_binned();
    set_default(); binned = 1; mon_clear(); pulse_start(); wait_done("R10");
    check("R11 binned frame length", frame_len, 147);
    check("R10 v2 falls three per line", v2_falls, 12);
    check("R10 hl falls", hl_falls, 18);
    check("R10 rg once per group", rg_rises, 10);
    check("R10 clamps", clamps, 4);
    check("R10 samples", samples, 4);
    check("R10 line starts", lstarts, 2);
    check("R10 order", order_bad, 0);
  endtask

  task automatic t_overclock();
    set_default(); ovc_pix = 2; ovc_lines = 1; rg_w = 2; clamp_off = 2;
    mon_clear(); pulse_start(); wait_done("R9 ovc");
    check("R11 overclock frame length", frame_len, 342);
    check("R7 overclock hl falls", hl_falls, 62);
    check("R8 rg width cycles", rg_cyc, 124);
    check("R8 overclock samples", samples, 56);
    check("R9 overclock line starts", lstarts, 7);
    check("R9 overclock v2 falls", v2_falls, 13);
  endtask

  task automatic t_flush_long();
    set_default(); fl_lines = 9; fl_pix = 10; mon_clear(); pulse_start(); wait_done("R3");
    check("R3 flush lines programmed", fl_v2, 9);
    check("R3 flush pixels programmed", fl_hl, 10);
    check("R11 long flush frame length", frame_len, 283);
  endtask

  task automatic t_latch();
    set_default(); mon_clear(); pulse_start();
    repeat (5) @(negedge clk);
    tv = 5; pix = 8; integ = 100; binned = 1; ovc_lines = 3;
    start = 1;
    @(negedge clk) start = 0;
    repeat (60) @(negedge clk);
    start = 1;
    @(negedge clk) start = 0;
    wait_done("R12");
    check("R12 frame length unchanged", frame_len, 255);
    check("R12 line starts unchanged", lstarts, 6);
    check("R2 start while busy ignored", fstarts, 1);
    repeat (3) @(negedge clk);
    check("R2 no restart after done", int'(busy), 0);
  endtask

  initial begin
    #(20 * 200000);
    check("watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    set_default(); mon_clear();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_full();
    t_binned();
    t_overclock();
    t_flush_long();
    t_latch();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule